// File: doc/BRIEF.md
# User Scalar Register Initial-State Packer

This block turns one dispatch's setup request into the series of user scalar register writes that give a wavefront its starting state. A 10-bit enable word selects which setup entries are wanted. The candidates are a four-word buffer descriptor, several 64-bit pointers and identifiers, two scratch words, a rounded private-size word, and three work-group counts. The block emits the enabled entries in a fixed order with dense register numbers. It stops writing once the user register budget is full.

The three work-group counts are not supplied from outside. The block computes each one itself as the ceiling of grid size over work-group size, using a bit-serial divider per dimension that runs before the writes begin. A pulse on the start input launches a dispatch. The write port then issues one index/data pair per clock. A done pulse closes the sequence and carries the total user register count and a divide-error flag, both of which stay valid until the next start.

Top module: `uinit_packer`

## Requirements
- R1: Enable bits map to entries as follows, and the entries are emitted in ascending bit order.
  - Bit 0: buffer descriptor, 4 words.
  - Bit 1: dispatch pointer, 2 words.
  - Bit 2: queue pointer, 2 words.
  - Bit 3: argument pointer, 2 words.
  - Bit 4: dispatch identifier, 2 words.
  - Bit 5: scratch init, 2 words.
  - Bit 6: private size, 1 word.
  - Bits 7, 8 and 9: work-group count for X, Y and Z, 1 word each.
- R2: Writes carry consecutive indices starting at 0, one per clock with no gaps. Disabled entries take no index.
- R3: At most MAX_REGS (16) writes are issued. Words past the budget are dropped, including the tail of an entry that would straddle the limit.
- R4: With done, user_cnt_o equals the summed word count of the enabled entries, saturated at 16. It holds that value until the next accepted start.
- R5: A 64-bit entry is written low word first. Descriptor words are written from bits [31:0] upward.
- R6: The work-group count for each dimension is (grid + wgsize - 1) / wgsize, computed without 32-bit overflow of the sum.
- R7: A zero work-group size makes that dimension's count 0. div_err_o is set at done when any enabled count entry has a zero work-group size, and holds until the next start.
- R8: The private size is rounded up to a multiple of 4 (modulo 2^32). That rounded value is the private-size entry and also the second scratch-init word. The first scratch-init word is the scratch offset input.
- R9: done_o pulses for one cycle, the cycle after the last write. With an all-zero enable word, it pulses the cycle after start. After reset, no write and no done are signalled.
- R10: A start pulse that arrives while a dispatch is in progress is ignored, and the running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a dispatch (accepted only when idle) |
| en_i | input | 10 | Entry enable word, sampled at start |
| desc_i | input | 128 | Buffer descriptor, word 0 in bits [31:0] |
| disp_ptr_i | input | 64 | Dispatch pointer |
| queue_ptr_i | input | 64 | Queue pointer |
| karg_ptr_i | input | 64 | Argument pointer |
| disp_id_i | input | 64 | Dispatch identifier |
| scr_off_i | input | 32 | Scratch area byte offset from the private base |
| priv_size_i | input | 32 | Per-work-item private byte size, unrounded |
| grid_size_i | input | 96 | Grid size, X in [31:0], Y in [63:32], Z in [95:64] |
| wg_size_i | input | 96 | Work-group size, same packing as grid_size_i |
| wr_valid_o | output | 1 | Register write strobe |
| wr_idx_o | output | 4 | User register index |
| wr_data_o | output | 32 | Register data |
| done_o | output | 1 | One-cycle completion pulse |
| user_cnt_o | output | 5 | Saturated user register count |
| div_err_o | output | 1 | Zero work-group size seen on an enabled count |

## Verification
Two functions can meet in one dispatch: budget truncation and the work-group count division. With every count enabled behind a full set of earlier entries, the last counts fall past the 16-register limit. The bench sweeps all 1024 enable words with varied sizes, including zero work-group sizes. For each write it judges the index and data against a model that builds the full unclipped word list arithmetically, then clips it at 16. A separate overlap is a start pulse injected in the middle of an emission together with an inverted enable word. The bench judges that the sequence, the count and the done timing are identical to an undisturbed run.

// File: rtl/uinit_pkg.sv
package uinit_pkg;
  localparam int NUM_ENT = 10;
  localparam int NUM_DIM = 3;
  localparam int ENT_DESC = 0;
  localparam int ENT_SCR  = 5;
  localparam int ENT_PRIV = 6;
  localparam int ENT_CNT0 = 7;

  typedef enum logic [1:0] {ST_IDLE, ST_DIV, ST_EMIT} st_e;

  function automatic int ent_words(input int k);
    if (k == ENT_DESC) return 4;
    else if (k < ENT_PRIV) return 2;
    else return 1;
  endfunction

  // first enabled entry at or above 'from', NUM_ENT if none
  function automatic int find_next(input logic [NUM_ENT-1:0] m, input int from);
    int r;
    r = NUM_ENT;
    for (int k = NUM_ENT - 1; k >= 0; k--)
      if (k >= from && m[k]) r = k;
    return r;
  endfunction

  function automatic int req_words(input logic [NUM_ENT-1:0] m);
    int s;
    s = 0;
    for (int k = 0; k < NUM_ENT; k++)
      if (m[k]) s += ent_words(k);
    return s;
  endfunction
endpackage

// File: rtl/uinit_ceil_div.sv
module uinit_ceil_div #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W:0]   num_i,
  input  logic [W-1:0] den_i,
  output logic         busy_o,
  output logic [W-1:0] quo_o
);
  localparam int NW = W + 1;
  localparam int CW = $clog2(NW + 1);

  logic [NW-1:0] q_q, r_q;
  logic [W-1:0]  d_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic [NW:0]   r_sh, r_sub;
  logic          ge;

  always_comb begin
    r_sh  = {r_q, q_q[NW-1]};
    ge    = r_sh >= {2'b00, d_q};
    r_sub = r_sh - {2'b00, d_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q    <= '0;
      r_q    <= '0;
      d_q    <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      q_q    <= num_i;
      r_q    <= '0;
      d_q    <= den_i;
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      q_q   <= {q_q[NW-2:0], ge};
      r_q   <= ge ? r_sub[NW-1:0] : r_sh[NW-1:0];
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CW'(NW - 1)) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign quo_o  = q_q[W-1:0];
endmodule

// File: rtl/uinit_word_sel.sv
module uinit_word_sel #(
  parameter int W  = 32,
  parameter int EW = 4
) (
  input  logic [EW-1:0]  ent_i,
  input  logic [1:0]     wrd_i,
  input  logic [4*W-1:0] desc_i,
  input  logic [2*W-1:0] disp_ptr_i,
  input  logic [2*W-1:0] queue_ptr_i,
  input  logic [2*W-1:0] karg_ptr_i,
  input  logic [2*W-1:0] disp_id_i,
  input  logic [W-1:0]   scr_off_i,
  input  logic [W-1:0]   priv_rnd_i,
  input  logic [3*W-1:0] cnt_i,
  output logic [W-1:0]   data_o
);
  function automatic logic [W-1:0] half(input logic [2*W-1:0] v, input logic hi);
    return hi ? v[2*W-1:W] : v[W-1:0];
  endfunction

  always_comb begin
    unique case (int'(ent_i))
      0:       data_o = desc_i[int'(wrd_i)*W +: W];
      1:       data_o = half(disp_ptr_i, wrd_i[0]);
      2:       data_o = half(queue_ptr_i, wrd_i[0]);
      3:       data_o = half(karg_ptr_i, wrd_i[0]);
      4:       data_o = half(disp_id_i, wrd_i[0]);
      5:       data_o = wrd_i[0] ? priv_rnd_i : scr_off_i;
      6:       data_o = priv_rnd_i;
      7:       data_o = cnt_i[W-1:0];
      8:       data_o = cnt_i[2*W-1:W];
      9:       data_o = cnt_i[3*W-1:2*W];
      default: data_o = '0;
    endcase
  end
endmodule

// File: rtl/uinit_packer.sv
module uinit_packer
  import uinit_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int MAX_REGS = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic [9:0]                    en_i,
  input  logic [4*DATA_W-1:0]           desc_i,
  input  logic [2*DATA_W-1:0]           disp_ptr_i,
  input  logic [2*DATA_W-1:0]           queue_ptr_i,
  input  logic [2*DATA_W-1:0]           karg_ptr_i,
  input  logic [2*DATA_W-1:0]           disp_id_i,
  input  logic [DATA_W-1:0]             scr_off_i,
  input  logic [DATA_W-1:0]             priv_size_i,
  input  logic [3*DATA_W-1:0]           grid_size_i,
  input  logic [3*DATA_W-1:0]           wg_size_i,
  output logic                          wr_valid_o,
  output logic [$clog2(MAX_REGS)-1:0]   wr_idx_o,
  output logic [DATA_W-1:0]             wr_data_o,
  output logic                          done_o,
  output logic [$clog2(MAX_REGS+1)-1:0] user_cnt_o,
  output logic                          div_err_o
);
  localparam int IW = $clog2(MAX_REGS);
  localparam int CW = $clog2(MAX_REGS + 1);
  localparam int EW = $clog2(NUM_ENT + 1);

  st_e               st_q;
  logic [NUM_ENT-1:0] en_q;
  logic [EW-1:0]     ent_q, ent_nxt;
  logic [1:0]        wrd_q;
  logic [IW-1:0]     ptr_q;
  logic              done_q, err_q;
  logic [CW-1:0]     cnt_q;
  logic              idle, accept, last_word, stop;
  logic [NUM_DIM-1:0] wg_zero, div_busy;
  logic [3*DATA_W-1:0] wg_cnt;
  logic [DATA_W-1:0] priv_rnd, priv_sum;
  logic [CW-1:0]     sat_cnt;
  logic [EW-1:0]     first_ent;

  assign idle   = (st_q == ST_IDLE);
  assign accept = idle && start_i;

  assign priv_sum = priv_size_i + DATA_W'(3);
  assign priv_rnd = {priv_sum[DATA_W-1:2], 2'b00};

  always_comb begin
    int s;
    s = req_words(en_i);
    sat_cnt = (s > MAX_REGS) ? CW'(MAX_REGS) : CW'(s);
  end

  assign first_ent = EW'(find_next(en_i, 0));

  // per-dimension ceiling divider
  for (genvar d = 0; d < NUM_DIM; d++) begin : g_dim
    logic [DATA_W-1:0] g, w, q;
    logic [DATA_W:0]   num;
    assign g          = grid_size_i[d*DATA_W +: DATA_W];
    assign w          = wg_size_i[d*DATA_W +: DATA_W];
    assign num        = {1'b0, g} + {1'b0, w} - (DATA_W+1)'(1);
    assign wg_zero[d] = (w == '0);

    uinit_ceil_div #(.W(DATA_W)) u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .start_i(accept && |en_i[ENT_CNT0 +: NUM_DIM]),
      .num_i  (num),
      .den_i  (w),
      .busy_o (div_busy[d]),
      .quo_o  (q)
    );
    assign wg_cnt[d*DATA_W +: DATA_W] = wg_zero[d] ? '0 : q;
  end

  always_comb begin
    last_word = (int'(wrd_q) == ent_words(int'(ent_q)) - 1);
    ent_nxt   = EW'(find_next(en_q, int'(ent_q) + 1));
    stop      = (ptr_q == IW'(MAX_REGS - 1)) ||
                (last_word && (int'(ent_nxt) == NUM_ENT));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      en_q   <= '0;
      ent_q  <= '0;
      wrd_q  <= '0;
      ptr_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          en_q  <= en_i;
          ent_q <= first_ent;
          wrd_q <= '0;
          ptr_q <= '0;
          cnt_q <= sat_cnt;
          err_q <= |(en_i[ENT_CNT0 +: NUM_DIM] & wg_zero);
          if (en_i == '0)                        done_q <= 1'b1;
          else if (|en_i[ENT_CNT0 +: NUM_DIM])   st_q   <= ST_DIV;
          else                                   st_q   <= ST_EMIT;
        end
        ST_DIV: if (div_busy == '0) st_q <= ST_EMIT;
        ST_EMIT: begin
          if (stop) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            ptr_q <= ptr_q + 1'b1;
            if (last_word) begin
              ent_q <= ent_nxt;
              wrd_q <= '0;
            end else begin
              wrd_q <= wrd_q + 1'b1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  uinit_word_sel #(.W(DATA_W), .EW(EW)) u_sel (
    .ent_i      (ent_q),
    .wrd_i      (wrd_q),
    .desc_i     (desc_i),
    .disp_ptr_i (disp_ptr_i),
    .queue_ptr_i(queue_ptr_i),
    .karg_ptr_i (karg_ptr_i),
    .disp_id_i  (disp_id_i),
    .scr_off_i  (scr_off_i),
    .priv_rnd_i (priv_rnd),
    .cnt_i      (wg_cnt),
    .data_o     (wr_data_o)
  );

  assign wr_valid_o = (st_q == ST_EMIT);
  assign wr_idx_o   = ptr_q;
  assign done_o     = done_q;
  assign user_cnt_o = cnt_q;
  assign div_err_o  = err_q;
endmodule

// File: rtl/uinit_packer_chk.sv
module uinit_packer_chk #(
  parameter int IW       = 4,
  parameter int CW       = 5,
  parameter int MAX_REGS = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [9:0]    en_i,
  input logic          idle_i,
  input logic          wr_valid_i,
  input logic [IW-1:0] wr_idx_i,
  input logic          done_i,
  input logic [CW-1:0] user_cnt_i
);
  assert_first_idx_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_valid_i) |-> wr_idx_i == '0);

  assert_dense_idx_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && $past(wr_valid_i)) |-> wr_idx_i == IW'($past(wr_idx_i) + 1'b1));

  assert_done_after_last_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_valid_i) |-> done_i);

  assert_done_alone_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !wr_valid_i);

  assert_empty_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && start_i && en_i == '0) |=> done_i);

  assert_cnt_cap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> user_cnt_i <= CW'(MAX_REGS));

  assert_busy_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && start_i) |=> (wr_valid_i || done_i));
endmodule

bind uinit_packer uinit_packer_chk #(.IW(IW), .CW(CW), .MAX_REGS(MAX_REGS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .en_i      (en_i),
  .idle_i    (idle),
  .wr_valid_i(wr_valid_o),
  .wr_idx_i  (wr_idx_o),
  .done_i    (done_o),
  .user_cnt_i(user_cnt_o)
);

// File: tb/uinit_packer_bench.sv
module uinit_packer_bench;
  logic         clk = 1'b0;
  logic         rst_ni;
  logic         start_i;
  logic [9:0]   en_i;
  logic [127:0] desc_i;
  logic [63:0]  disp_ptr_i, queue_ptr_i, karg_ptr_i, disp_id_i;
  logic [31:0]  scr_off_i, priv_size_i;
  logic [95:0]  grid_size_i, wg_size_i;
  logic         wr_valid_o, done_o, div_err_o;
  logic [3:0]   wr_idx_o;
  logic [31:0]  wr_data_o;
  logic [4:0]   user_cnt_o;

  int total = 0, bad = 0, wd = 0;
  logic [31:0] exp_w [0:17];
  int          exp_e [0:17];
  int          exp_len;

  always #2.5 clk = ~clk;

  uinit_packer u_uinit_packer (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .en_i(en_i),
    .desc_i(desc_i), .disp_ptr_i(disp_ptr_i), .queue_ptr_i(queue_ptr_i),
    .karg_ptr_i(karg_ptr_i), .disp_id_i(disp_id_i), .scr_off_i(scr_off_i),
    .priv_size_i(priv_size_i), .grid_size_i(grid_size_i), .wg_size_i(wg_size_i),
    .wr_valid_o(wr_valid_o), .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o),
    .done_o(done_o), .user_cnt_o(user_cnt_o), .div_err_o(div_err_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 180000) begin
      bad++;
      $display("FAIL watchdog act=%0d exp=<180000", wd);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [31:0] hsh(input int s, input int k);
    return 32'(s) * 32'h9E3779B9 + 32'(k) * 32'h01000193 + 32'h5A5A0000;
  endfunction

  task automatic set_vals(input int s);
    for (int i = 0; i < 4; i++) desc_i[i*32 +: 32] = hsh(s, i);
    disp_ptr_i  = {hsh(s, 5), hsh(s, 4)};
    queue_ptr_i = {hsh(s, 7), hsh(s, 6)};
    karg_ptr_i  = {hsh(s, 9), hsh(s, 8)};
    disp_id_i   = {hsh(s, 11), hsh(s, 10)};
    scr_off_i   = hsh(s, 12);
    priv_size_i = 32'(s) * 32'd13 + 32'(s % 4);
    for (int d = 0; d < 3; d++) begin
      grid_size_i[d*32 +: 32] = 32'(s) * 32'd1103 + 32'(d * 7);
      wg_size_i[d*32 +: 32]   = 32'((s + d) % 9);
    end
  endtask

  function automatic logic [31:0] ceil_cnt(input int d);
    longint g, w;
    g = longint'(grid_size_i[d*32 +: 32]);
    w = longint'(wg_size_i[d*32 +: 32]);
    if (w == 0) return 32'd0;
    return 32'((g + w - 1) / w);
  endfunction

  function automatic logic [31:0] word_of(input int k, input int w);
    logic [31:0] pr;
    pr = 32'((longint'(priv_size_i) + 3) & ~longint'(3));
    case (k)
      0: return desc_i[w*32 +: 32];
      1: return w == 0 ? disp_ptr_i[31:0] : disp_ptr_i[63:32];
      2: return w == 0 ? queue_ptr_i[31:0] : queue_ptr_i[63:32];
      3: return w == 0 ? karg_ptr_i[31:0] : karg_ptr_i[63:32];
      4: return w == 0 ? disp_id_i[31:0] : disp_id_i[63:32];
      5: return w == 0 ? scr_off_i : pr;
      6: return pr;
      default: return ceil_cnt(k - 7);
    endcase
  endfunction

  task automatic build_exp(input logic [9:0] m);
    int sz [0:9] = '{4, 2, 2, 2, 2, 2, 1, 1, 1, 1};
    exp_len = 0;
    for (int k = 0; k < 10; k++)
      if (m[k])
        for (int w = 0; w < sz[k]; w++) begin
          exp_w[exp_len] = word_of(k, w);
          exp_e[exp_len] = k;
          exp_len++;
        end
  endtask

  function automatic string tag_of(input int k);
    if (k < 5) return "R1/R5";
    if (k < 7) return "R1/R8";
    return "R1/R6";
  endfunction

  task automatic run_case(input logic [9:0] m, input bit poke);
    int nwr, last, cyc, exp_n;
    bit got_done;
    logic exp_err;
    build_exp(m);
    exp_n   = exp_len > 16 ? 16 : exp_len;
    exp_err = 1'b0;
    for (int d = 0; d < 3; d++)
      if (m[7+d] && wg_size_i[d*32 +: 32] == 0) exp_err = 1'b1;
    @(negedge clk);
    en_i = m; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    nwr = 0; last = 0; cyc = 1; got_done = 0;
    while (cyc < 200 && !got_done) begin
      start_i = 1'b0; en_i = m;
      if (wr_valid_o) begin
        check(wr_idx_o == 4'(nwr), "R2 index", longint'(wr_idx_o), longint'(nwr));
        if (nwr < 18)
          check(wr_data_o == exp_w[nwr], tag_of(exp_e[nwr]), longint'(wr_data_o), longint'(exp_w[nwr]));
        nwr++; last = cyc;
        if (poke && nwr == 2) begin
          start_i = 1'b1; en_i = ~m;   // R10: must be ignored
        end
      end
      if (done_o) begin
        got_done = 1;
        check(user_cnt_o == 5'(exp_n), "R4 count", longint'(user_cnt_o), longint'(exp_n));
        check(div_err_o == exp_err, "R7 error flag", longint'(div_err_o), longint'(exp_err));
        check(cyc == (nwr == 0 ? 1 : last + 1), "R9 done timing", longint'(cyc), longint'(nwr == 0 ? 1 : last + 1));
      end else begin
        @(negedge clk);
        cyc++;
      end
    end
    start_i = 1'b0; en_i = m;
    check(got_done, "R9 done seen", longint'(got_done), 1);
    check(nwr == exp_n, poke ? "R10/R3 write count" : "R3 write count", longint'(nwr), longint'(exp_n));
  endtask

  initial begin
    rst_ni = 1'b0; start_i = 1'b0; en_i = '0;
    set_vals(0);
    repeat (3) @(negedge clk);
    check(!wr_valid_o && !done_o, "R9 reset state", longint'({wr_valid_o, done_o}), 0);
    check(user_cnt_o == 0 && !div_err_o, "R4 reset count", longint'(user_cnt_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // full sweep of enable words
    for (int m = 0; m < 1024; m++) begin
      set_vals(m);
      run_case(10'(m), (m % 97) == 5);
    end

    // R6 boundaries: overflow-free sum, exact, one, grid below size; R7 zero size
    set_vals(3);
    grid_size_i = {32'd0, 32'd64, 32'hFFFF_FFFF};
    wg_size_i   = {32'd5, 32'd64, 32'd2};
    run_case(10'h380, 0);
    grid_size_i = {32'd7, 32'hFFFF_FFFF, 32'd1};
    wg_size_i   = {32'd100, 32'd1, 32'hFFFF_FFFF};
    run_case(10'h380, 0);
    wg_size_i   = {32'd3, 32'd0, 32'd4};
    run_case(10'h380, 0);
    run_case(10'h280, 0);   // zero size on a disabled count: no error
    // R3: all enabled, counts Y and Z fall past the budget
    set_vals(77);
    run_case(10'h3FF, 1);
    // R8: rounding wraps at the top of the range
    priv_size_i = 32'hFFFF_FFFE;
    run_case(10'h060, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule